// File: doc/BRIEF.md
# Pipeline Hazard Interlock and Bypass Control

This block is the hazard controller for an in-order scalar pipeline with fetch, decode, register-read, ALU, memory and write-back stages. Each cycle it takes the register specifiers of the instruction sitting in register-read. It compares both source registers against the destinations of the older instructions still in flight in the ALU, memory and write-back stages. From that comparison it picks, for each operand, where the operand value must come from.

The block keeps its own small shadow of the destination register, write flag and load flag of the instructions in those three later stages. It advances that shadow in step with the pipeline. A load in the ALU stage whose result a register-read source needs cannot be bypassed in time. In that case the controller freezes fetch, decode and register-read and drops a nop into the ALU stage. When the branch in the ALU stage resolves as mispredicted, the controller squashes the instructions in fetch, decode and register-read into nops and redirects fetch. The datapath, register file and caches sit outside the block.

Top module: `pipe_hazard_ctrl`

## Requirements
- R1: Each operand select uses the code 0 for the register file, 1 for the ALU-stage result, 2 for the memory-stage result and 3 for the write-back-stage result. An operand selects a stage when its source number equals that stage's destination and that stage holds a valid instruction with its write flag set.
- R2: When several stages match an operand, the youngest one wins: ALU before memory, and memory before write-back.
- R3: A destination of register 0, or a destination whose write flag is low, never matches. It causes neither a bypass nor a stall.
- R4: Suppose a valid register-read source matches a load in the ALU stage. Then en_if, en_id and en_rd go low and bubble_alu goes high in that cycle, and the ALU stage holds a nop in the next cycle.
- R5: A load stall lasts exactly one cycle. In the next cycle the held instruction bypasses the loaded value from the memory stage with code 2, and a load in the memory stage never stalls.
- R6: On br_mispredict, kill_id, kill_rd, bubble_alu and redirect are all high in that cycle. The squashed register-read instruction never becomes a bypass source afterwards.
- R7: A mispredict and a load stall in the same cycle resolve as a flush: all three enables stay high.
- R8: When rd_valid is low, the block raises no stall and both selects are 0. The slot enters the ALU stage as a nop.
- R9: Reset clears the in-flight shadow. After reset, no stage matches until new instructions have entered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_valid | input | 1 | Register-read stage holds a real instruction |
| rd_src_a | input | REG_AW | First source register number |
| rd_src_b | input | REG_AW | Second source register number |
| rd_dest | input | REG_AW | Destination register number |
| rd_we | input | 1 | Instruction writes its destination |
| rd_is_load | input | 1 | Instruction is a load |
| br_mispredict | input | 1 | Branch in ALU stage resolved wrong |
| fwd_sel_a | output | 2 | Bypass select for first operand |
| fwd_sel_b | output | 2 | Bypass select for second operand |
| en_if | output | 1 | Fetch-side pipeline register enable |
| en_id | output | 1 | Fetch/decode pipeline register enable |
| en_rd | output | 1 | Decode/register-read pipeline register enable |
| bubble_alu | output | 1 | Load a nop into the ALU stage |
| kill_id | output | 1 | Replace the fetched instruction with a nop |
| kill_rd | output | 1 | Replace the decoded instruction with a nop |
| redirect | output | 1 | Steer fetch to the resolved branch target |

## Verification
The bench builds the block with its default 5-bit register number, giving 32 architectural registers. That width puts register 0 within reach alongside a run of more than twenty distinct registers, so one instruction stream never reuses a register by accident. The same stream can deliberately place one register in two or three stages at once, which exercises youngest-wins selection. It also exercises a load stall followed by memory-stage bypass, a squashed instruction that must never be bypassed, and a flush that collides with a load stall.

// File: rtl/hzc_pkg.sv
// Shared definitions for the hazard controller: bypass source codes and
// the layout of the tracked in-flight stages. Assumes three tracked stages.
package hzc_pkg;
    localparam int unsigned NUM_TRACKED = 3;  // ALU, memory, write-back
    localparam int unsigned NUM_SRC     = 2;  // two source operands
    localparam int unsigned SEL_W       = 2;

    typedef enum logic [SEL_W-1:0] {
        SRC_RF  = 2'd0,
        SRC_ALU = 2'd1,
        SRC_MEM = 2'd2,
        SRC_WB  = 2'd3
    } fwd_src_e;
endpackage

// File: rtl/hzc_tag_pipe.sv
// Shadow of the destination tags held by the ALU, memory and write-back
// stages. Entry 0 is the ALU stage. The tags always advance, because the later
// stages never stall. A bubble or an invalid slot enters as a dead entry.
// An entry is live only if it writes a nonzero register.
module hzc_tag_pipe #(
    parameter int unsigned REG_AW = 5,
    parameter int unsigned DEPTH  = hzc_pkg::NUM_TRACKED
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_we,
    input  logic              in_load,
    input  logic [REG_AW-1:0] in_dest,
    input  logic              insert_bubble,
    output logic              st_live [DEPTH],
    output logic [REG_AW-1:0] st_dest [DEPTH],
    output logic              head_load
);
    logic entry_live;

    // Decide whether the register-read slot enters the ALU stage as a producer.
    assign entry_live = in_valid & in_we & (in_dest != '0) & ~insert_bubble;

    // Track the load flag only for the ALU-stage entry.
    always_ff @(posedge clk) begin
        if (!rst_n) head_load <= 1'b0;
        else        head_load <= entry_live & in_load;
    end

    for (genvar k = 0; k < DEPTH; k++) begin : g_stage
        if (k == 0) begin : g_head
            // Load the ALU-stage tag from the register-read slot.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    st_live[k] <= 1'b0;
                    st_dest[k] <= '0;
                end else begin
                    st_live[k] <= entry_live;
                    st_dest[k] <= in_dest;
                end
            end
        end else begin : g_tail
            // Move the tag of the next younger stage down.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    st_live[k] <= 1'b0;
                    st_dest[k] <= '0;
                end else begin
                    st_live[k] <= st_live[k-1];
                    st_dest[k] <= st_dest[k-1];
                end
            end
        end
    end
endmodule

// File: rtl/hzc_operand_match.sv
// Compares one source register against every tracked stage. It returns the
// bypass source of the youngest match, and flags a match with an ALU-stage
// load. Assumes stage index 0 is the youngest stage.
module hzc_operand_match #(
    parameter int unsigned REG_AW = 5,
    parameter int unsigned DEPTH  = hzc_pkg::NUM_TRACKED
) (
    input  logic              rd_valid,
    input  logic [REG_AW-1:0] src,
    input  logic              st_live [DEPTH],
    input  logic [REG_AW-1:0] st_dest [DEPTH],
    input  logic              head_load,
    output hzc_pkg::fwd_src_e sel,
    output logic              load_hit
);
    logic [DEPTH-1:0] hit;

    for (genvar k = 0; k < DEPTH; k++) begin : g_cmp
        // Equality compare against one stage's live destination.
        assign hit[k] = rd_valid & st_live[k] & (st_dest[k] == src);
    end

    // Walk from the oldest stage to the youngest, so the youngest match wins.
    always_comb begin
        sel = hzc_pkg::SRC_RF;
        for (int k = DEPTH - 1; k >= 0; k--) begin
            if (hit[k]) sel = hzc_pkg::fwd_src_e'(hzc_pkg::SEL_W'(k + 1));
        end
    end

    assign load_hit = hit[0] & head_load;
endmodule

// File: rtl/hzc_stage_ctrl.sv
// Turns the per-operand load hits and the mispredict into the stage enables
// and the squash controls. A flush outranks a stall.
module hzc_stage_ctrl #(
    parameter int unsigned NSRC = hzc_pkg::NUM_SRC
) (
    input  logic [NSRC-1:0] load_hit,
    input  logic            mispredict,
    output logic            en_if,
    output logic            en_id,
    output logic            en_rd,
    output logic            bubble_alu,
    output logic            kill_id,
    output logic            kill_rd,
    output logic            redirect
);
    logic stall;

    // Allow a load-use stall only when no flush is pending.
    assign stall      = (|load_hit) & ~mispredict;
    assign en_if      = ~stall;
    assign en_id      = ~stall;
    assign en_rd      = ~stall;
    assign bubble_alu = stall | mispredict;
    assign kill_id    = mispredict;
    assign kill_rd    = mispredict;
    assign redirect   = mispredict;
endmodule

// File: rtl/pipe_hazard_ctrl.sv
// Hazard interlock and bypass control for the register-read stage of an
// in-order pipeline. Assumes the datapath honours the enables and squash
// controls in the same cycle. Assumes br_mispredict refers to the branch
// that occupies the ALU stage.
module pipe_hazard_ctrl #(
    parameter int unsigned REG_AW = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_valid,
    input  logic [REG_AW-1:0] rd_src_a,
    input  logic [REG_AW-1:0] rd_src_b,
    input  logic [REG_AW-1:0] rd_dest,
    input  logic              rd_we,
    input  logic              rd_is_load,
    input  logic              br_mispredict,
    output logic [1:0]        fwd_sel_a,
    output logic [1:0]        fwd_sel_b,
    output logic              en_if,
    output logic              en_id,
    output logic              en_rd,
    output logic              bubble_alu,
    output logic              kill_id,
    output logic              kill_rd,
    output logic              redirect
);
    localparam int unsigned DEPTH = hzc_pkg::NUM_TRACKED;
    localparam int unsigned NSRC  = hzc_pkg::NUM_SRC;

    logic              st_live  [DEPTH];
    logic [REG_AW-1:0] st_dest  [DEPTH];
    logic              head_load;
    logic [REG_AW-1:0] src_vec  [NSRC];
    hzc_pkg::fwd_src_e sel_vec  [NSRC];
    logic [NSRC-1:0]   load_hit;

    assign src_vec[0] = rd_src_a;
    assign src_vec[1] = rd_src_b;

    hzc_tag_pipe #(.REG_AW(REG_AW), .DEPTH(DEPTH)) u_tags (
        .clk          (clk),
        .rst_n        (rst_n),
        .in_valid     (rd_valid),
        .in_we        (rd_we),
        .in_load      (rd_is_load),
        .in_dest      (rd_dest),
        .insert_bubble(bubble_alu),
        .st_live      (st_live),
        .st_dest      (st_dest),
        .head_load    (head_load)
    );

    for (genvar s = 0; s < NSRC; s++) begin : g_opnd
        hzc_operand_match #(.REG_AW(REG_AW), .DEPTH(DEPTH)) u_match (
            .rd_valid (rd_valid),
            .src      (src_vec[s]),
            .st_live  (st_live),
            .st_dest  (st_dest),
            .head_load(head_load),
            .sel      (sel_vec[s]),
            .load_hit (load_hit[s])
        );
    end

    assign fwd_sel_a = sel_vec[0];
    assign fwd_sel_b = sel_vec[1];

    hzc_stage_ctrl #(.NSRC(NSRC)) u_ctrl (
        .load_hit  (load_hit),
        .mispredict(br_mispredict),
        .en_if     (en_if),
        .en_id     (en_id),
        .en_rd     (en_rd),
        .bubble_alu(bubble_alu),
        .kill_id   (kill_id),
        .kill_rd   (kill_rd),
        .redirect  (redirect)
    );
endmodule

// File: rtl/hzc_checker.sv
// Property checker for pipe_hazard_ctrl, attached by bind. It observes the
// ports only.
module hzc_checker #(
    parameter int unsigned REG_AW = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd_valid,
    input logic [REG_AW-1:0] rd_src_a,
    input logic [REG_AW-1:0] rd_src_b,
    input logic [REG_AW-1:0] rd_dest,
    input logic              rd_we,
    input logic              rd_is_load,
    input logic              br_mispredict,
    input logic [1:0]        fwd_sel_a,
    input logic [1:0]        fwd_sel_b,
    input logic              en_if,
    input logic              en_id,
    input logic              en_rd,
    input logic              bubble_alu,
    input logic              kill_id,
    input logic              kill_rd,
    input logic              redirect
);
    // R4
    load_use_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rd_valid && rd_we && rd_is_load && rd_dest != '0 && en_rd && !redirect)
         && rd_valid && !br_mispredict
         && (rd_src_a == $past(rd_dest) || rd_src_b == $past(rd_dest)))
        |-> (!en_rd && bubble_alu));

    // R4
    stall_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en_rd |-> (!en_if && !en_id && bubble_alu && !redirect));

    // R5
    single_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en_rd |=> en_rd);

    // R6
    squashed_not_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        redirect |=> (fwd_sel_a != 2'd1 && fwd_sel_b != 2'd1));

    // R7
    flush_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        br_mispredict |-> (en_if && en_id && en_rd && kill_id && kill_rd && bubble_alu && redirect));

    // R3
    zero_src_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_src_a == '0) |-> (fwd_sel_a == 2'd0));

    // R3
    zero_src_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_src_b == '0) |-> (fwd_sel_b == 2'd0));

    // R8
    idle_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid |-> (en_rd && fwd_sel_a == 2'd0 && fwd_sel_b == 2'd0));
endmodule

bind pipe_hazard_ctrl hzc_checker #(.REG_AW(REG_AW)) u_hzc_checker (
    .clk(clk), .rst_n(rst_n), .rd_valid(rd_valid), .rd_src_a(rd_src_a),
    .rd_src_b(rd_src_b), .rd_dest(rd_dest), .rd_we(rd_we),
    .rd_is_load(rd_is_load), .br_mispredict(br_mispredict),
    .fwd_sel_a(fwd_sel_a), .fwd_sel_b(fwd_sel_b), .en_if(en_if),
    .en_id(en_id), .en_rd(en_rd), .bubble_alu(bubble_alu),
    .kill_id(kill_id), .kill_rd(kill_rd), .redirect(redirect)
);

// File: tb/tb_pipe_hazard_ctrl.sv
`timescale 1ns/1ps
module tb_pipe_hazard_ctrl;
    localparam int unsigned AW = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rd_valid = 1'b0;
    logic [AW-1:0] rd_src_a = '0;
    logic [AW-1:0] rd_src_b = '0;
    logic [AW-1:0] rd_dest = '0;
    logic          rd_we = 1'b0;
    logic          rd_is_load = 1'b0;
    logic          br_mispredict = 1'b0;
    logic [1:0]    fwd_sel_a, fwd_sel_b;
    logic          en_if, en_id, en_rd, bubble_alu, kill_id, kill_rd, redirect;

    int tests = 0;
    int fails = 0;

    always #2 clk = ~clk;  // 250 MHz

    pipe_hazard_ctrl #(.REG_AW(AW)) dut (
        .clk(clk), .rst_n(rst_n), .rd_valid(rd_valid), .rd_src_a(rd_src_a),
        .rd_src_b(rd_src_b), .rd_dest(rd_dest), .rd_we(rd_we),
        .rd_is_load(rd_is_load), .br_mispredict(br_mispredict),
        .fwd_sel_a(fwd_sel_a), .fwd_sel_b(fwd_sel_b), .en_if(en_if),
        .en_id(en_id), .en_rd(en_rd), .bubble_alu(bubble_alu),
        .kill_id(kill_id), .kill_rd(kill_rd), .redirect(redirect)
    );

    // One register-read slot per cycle and the outputs expected for it.
    typedef struct packed {
        logic       v;
        logic [4:0] sa;
        logic [4:0] sb;
        logic [4:0] dst;
        logic       we;
        logic       ld;
        logic       mp;
        logic [1:0] ea;
        logic [1:0] eb;
        logic       est;
        logic       efl;
        logic [3:0] rq;
    } vec_t;

    localparam int NV = 26;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 5'd2,  5'd3,  5'd1,  1'b1, 1'b0, 1'b0, 2'd0, 2'd0, 1'b0, 1'b0, 4'd1}, // R1 no producers yet
        '{1'b1, 5'd1,  5'd1,  5'd4,  1'b1, 1'b0, 1'b0, 2'd1, 2'd1, 1'b0, 1'b0, 4'd1}, // R1 back-to-back ALU
        '{1'b1, 5'd1,  5'd4,  5'd5,  1'b1, 1'b0, 1'b0, 2'd2, 2'd1, 1'b0, 1'b0, 4'd1}, // R1 memory + ALU
        '{1'b1, 5'd1,  5'd5,  5'd6,  1'b1, 1'b0, 1'b0, 2'd3, 2'd1, 1'b0, 1'b0, 4'd1}, // R1 write-back
        '{1'b1, 5'd4,  5'd0,  5'd7,  1'b1, 1'b0, 1'b0, 2'd3, 2'd0, 1'b0, 1'b0, 4'd3}, // R3 source r0
        '{1'b1, 5'd6,  5'd7,  5'd7,  1'b1, 1'b0, 1'b0, 2'd2, 2'd1, 1'b0, 1'b0, 4'd1},
        '{1'b1, 5'd7,  5'd7,  5'd8,  1'b1, 1'b0, 1'b0, 2'd1, 2'd1, 1'b0, 1'b0, 4'd2}, // R2 ALU beats memory
        '{1'b1, 5'd7,  5'd8,  5'd9,  1'b0, 1'b0, 1'b0, 2'd2, 2'd1, 1'b0, 1'b0, 4'd2}, // R2 memory beats WB
        '{1'b1, 5'd9,  5'd9,  5'd10, 1'b1, 1'b0, 1'b0, 2'd0, 2'd0, 1'b0, 1'b0, 4'd3}, // R3 we low no match
        '{1'b1, 5'd10, 5'd0,  5'd11, 1'b1, 1'b1, 1'b0, 2'd1, 2'd0, 1'b0, 1'b0, 4'd1}, // load enters
        '{1'b1, 5'd11, 5'd2,  5'd12, 1'b1, 1'b0, 1'b0, 2'd0, 2'd0, 1'b1, 1'b0, 4'd4}, // R4 load-use stall
        '{1'b1, 5'd11, 5'd2,  5'd12, 1'b1, 1'b0, 1'b0, 2'd2, 2'd0, 1'b0, 1'b0, 4'd5}, // R5 held, bypass mem
        '{1'b1, 5'd12, 5'd11, 5'd13, 1'b1, 1'b0, 1'b0, 2'd1, 2'd3, 1'b0, 1'b0, 4'd5}, // R5 bubble not a source
        '{1'b1, 5'd13, 5'd0,  5'd14, 1'b1, 1'b1, 1'b0, 2'd1, 2'd0, 1'b0, 1'b0, 4'd1},
        '{1'b1, 5'd2,  5'd3,  5'd15, 1'b1, 1'b0, 1'b0, 2'd0, 2'd0, 1'b0, 1'b0, 4'd4}, // R4 load, no use
        '{1'b1, 5'd3,  5'd14, 5'd16, 1'b1, 1'b0, 1'b0, 2'd0, 2'd2, 1'b0, 1'b0, 4'd5}, // R5 load in mem, no stall
        '{1'b1, 5'd2,  5'd0,  5'd0,  1'b1, 1'b1, 1'b0, 2'd0, 2'd0, 1'b0, 1'b0, 4'd3}, // R3 load to r0
        '{1'b1, 5'd0,  5'd0,  5'd0,  1'b0, 1'b0, 1'b0, 2'd0, 2'd0, 1'b0, 1'b0, 4'd3}, // R3 r0 load no stall
        '{1'b1, 5'd16, 5'd16, 5'd17, 1'b1, 1'b0, 1'b1, 2'd3, 2'd3, 1'b0, 1'b1, 4'd6}, // R6 mispredict
        '{1'b1, 5'd17, 5'd0,  5'd18, 1'b1, 1'b0, 1'b0, 2'd0, 2'd0, 1'b0, 1'b0, 4'd6}, // R6 squashed r17
        '{1'b1, 5'd18, 5'd0,  5'd19, 1'b1, 1'b1, 1'b0, 2'd1, 2'd0, 1'b0, 1'b0, 4'd1},
        '{1'b1, 5'd19, 5'd0,  5'd20, 1'b1, 1'b0, 1'b1, 2'd1, 2'd0, 1'b0, 1'b1, 4'd7}, // R7 flush over stall
        '{1'b1, 5'd20, 5'd19, 5'd21, 1'b1, 1'b0, 1'b0, 2'd0, 2'd2, 1'b0, 1'b0, 4'd7}, // R7 squash took effect
        '{1'b1, 5'd0,  5'd0,  5'd22, 1'b1, 1'b1, 1'b0, 2'd0, 2'd0, 1'b0, 1'b0, 4'd1},
        '{1'b0, 5'd22, 5'd22, 5'd23, 1'b1, 1'b0, 1'b0, 2'd0, 2'd0, 1'b0, 1'b0, 4'd8}, // R8 idle slot
        '{1'b1, 5'd23, 5'd22, 5'd24, 1'b1, 1'b0, 1'b0, 2'd0, 2'd2, 1'b0, 1'b0, 4'd8}  // R8 idle left a nop
    };

    task automatic check(input string req, input string what, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic drive(input logic v, input logic [4:0] sa, input logic [4:0] sb,
                         input logic [4:0] d, input logic we, input logic ld, input logic mp);
        rd_valid = v; rd_src_a = sa; rd_src_b = sb; rd_dest = d;
        rd_we = we; rd_is_load = ld; br_mispredict = mp;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin : main
        string tag;
        // R9: held in reset with a would-be producer on the inputs
        drive(1'b1, 5'd1, 5'd1, 5'd1, 1'b1, 1'b1, 1'b0);
        repeat (3) @(posedge clk);
        @(negedge clk); #1;
        check("R9", "sel_a in reset", fwd_sel_a, 0);
        check("R9", "en_rd in reset", en_rd, 1);

        // Vector walk; reset released together with the first slot
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            rst_n = 1'b1;
            drive(VEC[i].v, VEC[i].sa, VEC[i].sb, VEC[i].dst, VEC[i].we, VEC[i].ld, VEC[i].mp);
            #1;
            tag = $sformatf("R%0d@%0d", VEC[i].rq, i);
            check(tag, "en_rd (R4)", en_rd, !VEC[i].est);
            check(tag, "en_id (R4)", en_id, !VEC[i].est);
            check(tag, "en_if (R4)", en_if, !VEC[i].est);
            check(tag, "bubble_alu (R4/R6)", bubble_alu, VEC[i].est | VEC[i].efl);
            check(tag, "kill_id (R6)", kill_id, VEC[i].efl);
            check(tag, "kill_rd (R6)", kill_rd, VEC[i].efl);
            check(tag, "redirect (R6)", redirect, VEC[i].efl);
            if (!VEC[i].est) begin
                check(tag, "fwd_sel_a (R1)", fwd_sel_a, VEC[i].ea);
                check(tag, "fwd_sel_b (R1)", fwd_sel_b, VEC[i].eb);
            end
        end

        // R9: a load in flight is forgotten by a mid-run reset
        @(negedge clk);
        drive(1'b1, 5'd1, 5'd2, 5'd5, 1'b1, 1'b1, 1'b0);
        @(negedge clk);
        rst_n = 1'b0;
        drive(1'b0, 5'd0, 5'd0, 5'd0, 1'b0, 1'b0, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        drive(1'b1, 5'd5, 5'd5, 5'd6, 1'b1, 1'b0, 1'b0);
        #1;
        check("R9", "en_rd after reset", en_rd, 1);
        check("R9", "fwd_sel_a after reset", fwd_sel_a, 0);

        // R4: load-use stall on the second operand only
        @(negedge clk);
        drive(1'b1, 5'd0, 5'd0, 5'd9, 1'b1, 1'b1, 1'b0);
        @(negedge clk);
        drive(1'b1, 5'd3, 5'd9, 5'd10, 1'b1, 1'b0, 1'b0);
        #1;
        check("R4", "en_rd on operand b load", en_rd, 0);
        @(negedge clk); #1;
        check("R5", "en_rd after one stall", en_rd, 1);
        check("R5", "fwd_sel_b from memory", fwd_sel_b, 2);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule